// File: doc/BRIEF.md
# Adaptive Charge Current Governor

This block decides the charge-current code that a battery charger's regulator applies. The code is 4 bits wide. Code k stands for 400 mA + k x 100 mA, so codes 0 to 12 cover 400 mA to 1600 mA. Three limits feed the decision:

- the code software has programmed;
- an optional automatic search that probes how much current the input source can carry before its voltage sags;
- a die-temperature derating stage that cuts the current when the silicon runs hot.

The smallest of the three becomes the target. The applied code never jumps to the target. It walks toward it one code per step interval, and a step interval is a fixed number of pulses on a slow timebase tick input. This keeps regulator disturbances small.

Alongside the current code, the block passes the thermal-shutdown flag on as a registered halt request. It also raises a one-cycle strobe each time the warning, hot-1 or hot-2 die-temperature flag rises, so the system can raise an interrupt. All inputs and outputs are plain level or strobe controls. Nothing flows as a stream, so there is no handshake.

Top module: `charge_current_governor`

## Requirements
- R1: After reset the applied code is 0 (400 mA), the halt flag is 0 and all three event strobes are 0.
- R2: The applied code changes by exactly one code per step interval toward the target, and never changes between intervals. One interval is STEP_TICKS pulses of `tick_i` (default 4).
- R3: With the search enabled, the search limit restarts at code 0 when the enable rises. While seeking, the limit rises one code at an interval boundary, and only once the applied code has caught up with it. Each rising edge of the undervoltage flag lowers the limit by one code (saturating at 0) and freezes it until the next rising edge.
- R4: The search limit never takes the target above the programmed code. With the search disabled, the search has no effect on the target.
- R5: With derating enabled, a hot-1 flag lowers the target to the applied code at that moment minus 2, saturated at code 0.
- R6: With derating enabled, a hot-2 flag lowers the target to code 0.
- R7: A derated target is lifted only when the warning and hot-1 flags are both low and hot-2 is low.
- R8: With derating disabled, the thermal flags never reduce the applied code.
- R9: `halt_o` equals `therm_sd_i` delayed by one clock, whatever the derating setting.
- R10: Each of `ev_warn_o`, `ev_hot1_o` and `ev_hot2_o` is high for exactly the one cycle after its flag is first seen high following a low sample.
- R11: The target is the minimum of the programmed code, the search limit and the thermal limit. A programmed code above 12 is treated as 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase pulse, one clock wide |
| prog_code_i | input | 4 | Programmed charge-current code |
| search_en_i | input | 1 | Enables the automatic input-voltage search |
| uv_flag_i | input | 1 | Deglitched input undervoltage flag |
| derate_en_i | input | 1 | Enables automatic thermal derating |
| therm_warn_i | input | 1 | Die temperature above the warning threshold |
| therm_hot1_i | input | 1 | Die temperature above hot threshold 1 |
| therm_hot2_i | input | 1 | Die temperature above hot threshold 2 |
| therm_sd_i | input | 1 | Die temperature above the shutdown threshold |
| applied_code_o | output | 4 | Charge-current code sent to the regulator |
| halt_o | output | 1 | Charge halt request on thermal shutdown |
| ev_warn_o | output | 1 | Warning-threshold event strobe |
| ev_hot1_o | output | 1 | Hot-1 event strobe |
| ev_hot2_o | output | 1 | Hot-2 event strobe |

## Verification
The checker assumes the thermal and shutdown flags are low while reset is held, and that the thermal flags are nested: hot-2 implies hot-1, which implies warning. The derating assertion also assumes a hot-2 condition persists for several clocks. The stimulus raises and clears the thermal flags in nested order at separate falling clock edges, holds every flag low through reset, and keeps the ticks in whole multiples of the step interval. This keeps each check aligned with an interval boundary.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic [0:0] {
    SRCH_SEEK,
    SRCH_HOLD
  } srch_state_t;

  typedef enum logic [1:0] {
    DR_NONE,
    DR_STEP,
    DR_FLOOR
  } derate_t;
endpackage

// File: rtl/cg_step_timer.sv
module cg_step_timer #(
  parameter int STEP_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic step_o
);
  generate
    if (STEP_TICKS <= 1) begin : g_direct
      assign step_o = tick_i;
    end else begin : g_count
      localparam int CNT_W = $clog2(STEP_TICKS);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_TICKS - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (tick_i) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      assign step_o = tick_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/cg_search.sv
module cg_search
  import cg_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              uv_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] prog_i,
  input  logic [CODE_W-1:0] applied_i,
  output logic [CODE_W-1:0] limit_o
);
  srch_state_t       state_q;
  logic [CODE_W-1:0] code_q;
  logic              en_q;
  logic              uv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRCH_SEEK;
      code_q  <= '0;
      en_q    <= 1'b0;
      uv_q    <= 1'b0;
    end else begin
      en_q <= en_i;
      uv_q <= uv_i;
      if (en_i && !en_q) begin
        state_q <= SRCH_SEEK;
        code_q  <= '0;
      end else if (en_i) begin
        if (uv_i && !uv_q) begin
          state_q <= SRCH_HOLD;
          code_q  <= (code_q == '0) ? '0 : code_q - 1'b1;
        end else if (state_q == SRCH_SEEK && step_i &&
                     applied_i == code_q && code_q < prog_i) begin
          code_q <= code_q + 1'b1;
        end
      end
    end
  end

  assign limit_o = en_i ? code_q : '1;
endmodule

// File: rtl/cg_thermal.sv
module cg_thermal
  import cg_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int DROP_STEPS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              derate_en_i,
  input  logic              warn_i,
  input  logic              hot1_i,
  input  logic              hot2_i,
  input  logic              sd_i,
  input  logic [CODE_W-1:0] applied_i,
  output logic [CODE_W-1:0] limit_o,
  output logic              halt_o,
  output logic [2:0]        ev_o
);
  localparam logic [CODE_W-1:0] DROP = CODE_W'(DROP_STEPS);

  derate_t           level_q;
  logic [CODE_W-1:0] cap_q;
  logic [2:0]        flags;
  logic [2:0]        flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= DR_NONE;
      cap_q   <= '0;
    end else if (!derate_en_i) begin
      level_q <= DR_NONE;
    end else if (hot2_i) begin
      level_q <= DR_FLOOR;
    end else if (hot1_i && level_q == DR_NONE) begin
      level_q <= DR_STEP;
      cap_q   <= (applied_i >= DROP) ? applied_i - DROP : '0;
    end else if (!warn_i && !hot1_i) begin
      level_q <= DR_NONE;
    end
  end

  always_comb begin
    case (level_q)
      DR_STEP:  limit_o = cap_q;
      DR_FLOOR: limit_o = '0;
      default:  limit_o = '1;
    endcase
  end

  assign flags = {hot2_i, hot1_i, warn_i};

  generate
    for (genvar i = 0; i < 3; i++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flags_q[i] <= 1'b0;
          ev_o[i]    <= 1'b0;
        end else begin
          flags_q[i] <= flags[i];
          ev_o[i]    <= flags[i] && !flags_q[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_o <= 1'b0;
    else        halt_o <= sd_i;
  end
endmodule

// File: rtl/cg_ramp.sv
module cg_ramp #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [CODE_W-1:0] target_i,
  output logic [CODE_W-1:0] applied_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_o <= '0;
    end else if (step_i) begin
      if (applied_o < target_i)      applied_o <= applied_o + 1'b1;
      else if (applied_o > target_i) applied_o <= applied_o - 1'b1;
    end
  end
endmodule

// File: rtl/charge_current_governor.sv
module charge_current_governor #(
  parameter int CODE_W     = 4,
  parameter int MAX_CODE   = 12,
  parameter int STEP_TICKS = 4,
  parameter int DROP_STEPS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] prog_code_i,
  input  logic              search_en_i,
  input  logic              uv_flag_i,
  input  logic              derate_en_i,
  input  logic              therm_warn_i,
  input  logic              therm_hot1_i,
  input  logic              therm_hot2_i,
  input  logic              therm_sd_i,
  output logic [CODE_W-1:0] applied_code_o,
  output logic              halt_o,
  output logic              ev_warn_o,
  output logic              ev_hot1_o,
  output logic              ev_hot2_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(MAX_CODE);

  logic              step;
  logic [CODE_W-1:0] prog_c;
  logic [CODE_W-1:0] srch_lim;
  logic [CODE_W-1:0] therm_lim;
  logic [CODE_W-1:0] target;
  logic [CODE_W-1:0] min_a;
  logic [2:0]        ev;

  assign prog_c = (prog_code_i > CODE_MAX) ? CODE_MAX : prog_code_i;

  always_comb begin
    min_a  = (prog_c < srch_lim) ? prog_c : srch_lim;
    target = (min_a < therm_lim) ? min_a : therm_lim;
  end

  cg_step_timer #(.STEP_TICKS(STEP_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .step_o(step)
  );

  cg_search #(.CODE_W(CODE_W)) search_i (
    .clk(clk), .rst_n(rst_n), .en_i(search_en_i), .uv_i(uv_flag_i),
    .step_i(step), .prog_i(prog_c), .applied_i(applied_code_o),
    .limit_o(srch_lim)
  );

  cg_thermal #(.CODE_W(CODE_W), .DROP_STEPS(DROP_STEPS)) thermal_i (
    .clk(clk), .rst_n(rst_n), .derate_en_i(derate_en_i),
    .warn_i(therm_warn_i), .hot1_i(therm_hot1_i), .hot2_i(therm_hot2_i),
    .sd_i(therm_sd_i), .applied_i(applied_code_o), .limit_o(therm_lim),
    .halt_o(halt_o), .ev_o(ev)
  );

  cg_ramp #(.CODE_W(CODE_W)) ramp_i (
    .clk(clk), .rst_n(rst_n), .step_i(step), .target_i(target),
    .applied_o(applied_code_o)
  );

  assign ev_warn_o = ev[0];
  assign ev_hot1_o = ev[1];
  assign ev_hot2_o = ev[2];
endmodule

// File: rtl/charge_current_governor_chk.sv
module charge_current_governor_chk #(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              derate_en_i,
  input logic              therm_warn_i,
  input logic              therm_hot2_i,
  input logic              therm_sd_i,
  input logic [CODE_W-1:0] applied_code_o,
  input logic              halt_o,
  input logic              ev_warn_o
);
  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    applied_code_o != $past(applied_code_o) |->
      (applied_code_o == $past(applied_code_o) + 1'b1 ||
       applied_code_o + 1'b1 == $past(applied_code_o)));

  // R11
  code_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    applied_code_o <= CODE_W'(MAX_CODE));

  // R6
  hot2_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (derate_en_i && therm_hot2_i && $past(derate_en_i && therm_hot2_i) &&
     $past(derate_en_i && therm_hot2_i, 2)) |->
      applied_code_o <= $past(applied_code_o));

  // R9
  halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(therm_sd_i) |=> halt_o);

  // R10
  warn_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_warn_o |-> $past(therm_warn_i));

  // R10
  warn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_warn_o |=> !ev_warn_o);
endmodule

bind charge_current_governor charge_current_governor_chk #(
  .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .derate_en_i(derate_en_i),
  .therm_warn_i(therm_warn_i), .therm_hot2_i(therm_hot2_i),
  .therm_sd_i(therm_sd_i), .applied_code_o(applied_code_o),
  .halt_o(halt_o), .ev_warn_o(ev_warn_o)
);

// File: tb/charge_current_governor_tb_top.sv
module charge_current_governor_tb_top;
  localparam int STEP_TICKS = 4;
  localparam int NVEC = 7;
  // {prog[15:12], steps[11:4], expected[3:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h6011, 16'h6034, 16'h6056, 16'h2024, 16'h2052, 16'hF14C, 16'h0140
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] prog = 4'd0;
  logic       search_en = 1'b0;
  logic       uv = 1'b0;
  logic       derate_en = 1'b0;
  logic       warn = 1'b0;
  logic       hot1 = 1'b0;
  logic       hot2 = 1'b0;
  logic       sd = 1'b0;
  logic [3:0] applied;
  logic       halt;
  logic       ev_warn;
  logic       ev_hot1;
  logic       ev_hot2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  charge_current_governor #(.STEP_TICKS(STEP_TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .prog_code_i(prog),
    .search_en_i(search_en), .uv_flag_i(uv), .derate_en_i(derate_en),
    .therm_warn_i(warn), .therm_hot1_i(hot1), .therm_hot2_i(hot2),
    .therm_sd_i(sd), .applied_code_o(applied), .halt_o(halt),
    .ev_warn_o(ev_warn), .ev_hot1_o(ev_hot1), .ev_hot2_o(ev_hot2)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_steps(input int n);
    for (int i = 0; i < n * STEP_TICKS; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 applied", applied, 0);
    check("R1 halt", halt, 0);
    check("R1 strobes", {ev_warn, ev_hot1, ev_hot2}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R2 / R11 vector walk
    for (int v = 0; v < NVEC; v++) begin
      prog = VEC[v][15:12];
      do_steps(int'(VEC[v][11:4]));
      check("R2 R11 ramp vector", applied, int'(VEC[v][3:0]));
    end

    // R3 search
    prog = 4'd10;
    search_en = 1'b1;
    do_steps(8);
    check("R3 search climb", applied, 4);
    @(negedge clk) uv = 1'b1;
    do_steps(1);
    check("R3 back-off", applied, 3);
    uv = 1'b0;
    do_steps(6);
    check("R3 hold", applied, 3);
    @(negedge clk) uv = 1'b1;
    do_steps(1);
    check("R3 second back-off", applied, 2);
    uv = 1'b0;

    // R4 clamp and disable
    @(negedge clk) search_en = 1'b0;
    prog = 4'd3;
    @(negedge clk) search_en = 1'b1;
    do_steps(20);
    check("R4 search capped by prog", applied, 3);
    search_en = 1'b0;
    prog = 4'd10;
    do_steps(10);
    check("R4 search disabled", applied, 10);

    // R5 R6 R7 R10 derating
    derate_en = 1'b1;
    @(negedge clk) warn = 1'b1;
    @(negedge clk);
    check("R10 warn strobe", ev_warn, 1);
    @(negedge clk);
    check("R10 warn strobe one cycle", ev_warn, 0);
    hot1 = 1'b1;
    @(negedge clk);
    check("R10 hot1 strobe", ev_hot1, 1);
    do_steps(1);
    check("R5 first step down", applied, 9);
    do_steps(3);
    check("R5 minus two", applied, 8);
    hot2 = 1'b1;
    @(negedge clk);
    check("R10 hot2 strobe", ev_hot2, 1);
    do_steps(10);
    check("R6 floor", applied, 0);
    hot2 = 1'b0;
    @(negedge clk) hot1 = 1'b0;
    do_steps(5);
    check("R7 held while warn", applied, 0);
    warn = 1'b0;
    do_steps(12);
    check("R7 restored", applied, 10);

    // R5 saturation at 0
    prog = 4'd1;
    do_steps(12);
    check("R5 setup", applied, 1);
    warn = 1'b1;
    @(negedge clk) hot1 = 1'b1;
    do_steps(3);
    check("R5 saturates at 0", applied, 0);
    hot1 = 1'b0;
    @(negedge clk) warn = 1'b0;
    do_steps(3);
    check("R7 restore after saturate", applied, 1);

    // R8 derate disabled
    derate_en = 1'b0;
    prog = 4'd10;
    do_steps(12);
    warn = 1'b1;
    @(negedge clk) hot1 = 1'b1;
    @(negedge clk) hot2 = 1'b1;
    do_steps(12);
    check("R8 no reduction", applied, 10);
    hot2 = 1'b0;
    @(negedge clk) hot1 = 1'b0;
    @(negedge clk) warn = 1'b0;

    // R9 halt
    @(negedge clk) sd = 1'b1;
    @(negedge clk);
    check("R9 halt set", halt, 1);
    sd = 1'b0;
    @(negedge clk);
    check("R9 halt clear", halt, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule